// File: doc/BRIEF.md
# Fixed-Priority Exception Arbiter

This block chooses which pending exception a microcontroller interrupt controller should service next. Each candidate has an effective signed priority. A few exceptions have negative priorities fixed by the architecture. The rest have an 8-bit unsigned priority supplied from outside. The block compares all enabled, pending candidates and reports the winner's exception number, its effective priority and a valid flag. All three outputs are registered.

A strap input selects the legacy profile or the security-extended profile. In the security-extended profile, the reset exception sits one level higher than it does in the legacy profile. That profile also has a second hard fault for the non-secure world. A one-bit routing control, written through a simple strobe-and-data port, moves the secure hard fault from just below the non-maskable interrupt to just above it. Arbitration then uses the new ordering on the next cycle. Preemption against the running priority, vector fetch and the register map are handled elsewhere.

Exception numbering: 0 reset, 1 non-maskable interrupt (NMI), 2 secure hard fault (the only hard fault in the legacy profile), 3 non-secure hard fault, 4 and up configurable.

Top module: `excp_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `win_valid_o` is 0, `win_num_o` is 0 and `win_prio_o` is 0 until a pending exception is sampled. The routing control bit starts at 0.
- R2: In the legacy profile (`prof_sec_i`=0), reset has priority -3, the NMI -2 and hard fault (number 2) -1.
- R3: In the security-extended profile (`prof_sec_i`=1), reset has priority -4, the NMI -2 and the non-secure hard fault (number 3) -1.
- R4: In the security-extended profile, the secure hard fault (number 2) has priority -3 when the routing bit is 1, so it beats the NMI. It has priority -1 when the bit is 0.
- R5: A write (`ctl_we_i`=1) loads `ctl_wdata_i` into the routing bit at that clock edge. The outputs registered at the following edge use the new value.
- R6: In the legacy profile, control writes are ignored and the routing bit stays 0. Exception number 3 is ignored.
- R7: Configurable exception n (n>=4) competes only when both `pend_i[n]` and `en_i[n]` are 1. It competes with priority equal to its 8-bit field `prio_i[(n-4)*8 +: 8]`, zero-extended to 10 signed bits.
- R8: The numerically lowest priority wins. On equal priority the lower exception number wins, so the secure hard fault beats the non-secure one at -1.
- R9: Exceptions 0 to 3 cannot be disabled; their `en_i` bits have no effect.
- R10: With no competing exception, `win_valid_o`=0, `win_num_o`=0 and `win_prio_o`=0. Every output reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_sec_i | input | 1 | Profile strap: 1 security-extended, 0 legacy |
| pend_i | input | NUM_EXC | Pending bit per exception number |
| en_i | input | NUM_EXC | Enable bit per exception (bits 0..3 unused) |
| prio_i | input | 8*(NUM_EXC-4) | Priorities of configurable exceptions, 8 bits each from number 4 up |
| ctl_we_i | input | 1 | Write strobe for the routing control bit |
| ctl_wdata_i | input | 1 | Value written to the routing control bit |
| win_valid_o | output | 1 | A winning exception exists |
| win_num_o | output | $clog2(NUM_EXC) | Winning exception number |
| win_prio_o | output | 10 | Winning effective priority, two's complement |

## Verification
The assertions assume that the profile strap does not change while the block is out of reset. They also assume that the pending, enable, priority and write inputs change only away from the rising clock edge. The stimulus changes the strap only while reset is held. It drives every other input on the falling edge. Random pending bits are kept sparse on the fixed exceptions so that each fixed ordering is reached often. Priorities are sometimes drawn from a small set so that ties between configurable exceptions occur.

// File: rtl/excp_arb_pkg.sv
package excp_arb_pkg;

  localparam int PRIO_W = 10;
  localparam int IDX_MAX_W = 8;
  localparam int CFG_PRIO_W = 8;
  localparam int NUM_FIXED = 4;

  typedef logic signed [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic                 vld;
    logic [IDX_MAX_W-1:0] idx;
    prio_t                prio;
  } cand_t;

  localparam prio_t PRIO_RST_SEC = prio_t'(-4);
  localparam prio_t PRIO_RST_LEG = prio_t'(-3);
  localparam prio_t PRIO_SHF_HI  = prio_t'(-3);
  localparam prio_t PRIO_NMI     = prio_t'(-2);
  localparam prio_t PRIO_HF_LO   = prio_t'(-1);

  // Left operand always carries the lower exception numbers; it wins ties.
  function automatic cand_t cand_pick(cand_t lo, cand_t hi);
    if (lo.vld && (!hi.vld || ($signed(lo.prio) <= $signed(hi.prio))))
      return lo;
    return hi;
  endfunction

endpackage

// File: rtl/excp_ctl_reg.sv
module excp_ctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic prof_sec_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic route_q
);

  logic route_d;
  logic route_ce;

  always_comb begin
    route_ce = we_i & prof_sec_i;
    route_d  = route_ce ? wdata_i : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= 1'b0;
    end else if (route_ce) begin
      route_q <= route_d;
    end
  end

endmodule

// File: rtl/excp_prio_map.sv
module excp_prio_map
  import excp_arb_pkg::*;
#(
  parameter int NUM_EXC = 16,
  localparam int NUM_CFG = NUM_EXC - NUM_FIXED
) (
  input  logic                       prof_sec_i,
  input  logic                       route_i,
  input  logic [NUM_EXC-1:0]         pend_i,
  input  logic [NUM_EXC-1:0]         en_i,
  input  logic [NUM_CFG*CFG_PRIO_W-1:0] prio_i,
  output cand_t                      cand_o [NUM_EXC]
);

  logic shf_high;
  assign shf_high = prof_sec_i & route_i;

  for (genvar gi = 0; gi < NUM_EXC; gi++) begin : g_map
    if (gi == 0) begin : g_rst
      assign cand_o[gi].vld  = pend_i[gi];
      assign cand_o[gi].prio = prof_sec_i ? PRIO_RST_SEC : PRIO_RST_LEG;
    end else if (gi == 1) begin : g_nmi
      assign cand_o[gi].vld  = pend_i[gi];
      assign cand_o[gi].prio = PRIO_NMI;
    end else if (gi == 2) begin : g_shf
      assign cand_o[gi].vld  = pend_i[gi];
      assign cand_o[gi].prio = shf_high ? PRIO_SHF_HI : PRIO_HF_LO;
    end else if (gi == 3) begin : g_nshf
      assign cand_o[gi].vld  = pend_i[gi] & prof_sec_i;
      assign cand_o[gi].prio = PRIO_HF_LO;
    end else begin : g_cfg
      assign cand_o[gi].vld  = pend_i[gi] & en_i[gi];
      assign cand_o[gi].prio = prio_t'({2'b00, prio_i[(gi-NUM_FIXED)*CFG_PRIO_W +: CFG_PRIO_W]});
    end
    assign cand_o[gi].idx = IDX_MAX_W'(gi);
  end

  logic unused_en;
  assign unused_en = ^en_i[NUM_FIXED-1:0];

endmodule

// File: rtl/excp_arb_tree.sv
module excp_arb_tree
  import excp_arb_pkg::*;
#(
  parameter int NUM_EXC = 16,
  localparam int LVLS = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1,
  localparam int LEAVES = 1 << LVLS
) (
  input  cand_t cand_i [NUM_EXC],
  output cand_t win_o
);

  cand_t node [1:2*LEAVES-1];

  for (genvar gj = 0; gj < LEAVES; gj++) begin : g_leaf
    if (gj < NUM_EXC) begin : g_real
      assign node[LEAVES+gj] = cand_i[gj];
    end else begin : g_pad
      assign node[LEAVES+gj] = '0;
    end
  end

  for (genvar gk = 1; gk < LEAVES; gk++) begin : g_node
    assign node[gk] = cand_pick(node[2*gk], node[2*gk+1]);
  end

  assign win_o = node[1];

endmodule

// File: rtl/excp_arbiter.sv
module excp_arbiter
  import excp_arb_pkg::*;
#(
  parameter int NUM_EXC = 16,
  localparam int NUM_CFG = NUM_EXC - NUM_FIXED,
  localparam int NUM_W = $clog2(NUM_EXC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prof_sec_i,
  input  logic [NUM_EXC-1:0]            pend_i,
  input  logic [NUM_EXC-1:0]            en_i,
  input  logic [NUM_CFG*CFG_PRIO_W-1:0] prio_i,
  input  logic                          ctl_we_i,
  input  logic                          ctl_wdata_i,
  output logic                          win_valid_o,
  output logic [NUM_W-1:0]              win_num_o,
  output logic [PRIO_W-1:0]             win_prio_o
);

  logic  route_q;
  cand_t cand [NUM_EXC];
  cand_t best;

  logic             valid_d;
  logic [NUM_W-1:0] num_d;
  prio_t            prio_d;

  excp_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .prof_sec_i (prof_sec_i),
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .route_q    (route_q)
  );

  excp_prio_map #(.NUM_EXC(NUM_EXC)) u_map (
    .prof_sec_i (prof_sec_i),
    .route_i    (route_q),
    .pend_i     (pend_i),
    .en_i       (en_i),
    .prio_i     (prio_i),
    .cand_o     (cand)
  );

  excp_arb_tree #(.NUM_EXC(NUM_EXC)) u_tree (
    .cand_i (cand),
    .win_o  (best)
  );

  always_comb begin
    valid_d = best.vld;
    num_d   = best.vld ? best.idx[NUM_W-1:0] : '0;
    prio_d  = best.vld ? best.prio : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_o <= 1'b0;
      win_num_o   <= '0;
      win_prio_o  <= '0;
    end else begin
      win_valid_o <= valid_d;
      win_num_o   <= num_d;
      win_prio_o  <= prio_d;
    end
  end

  logic unused_idx;
  assign unused_idx = ^best.idx;

endmodule

// File: rtl/excp_arbiter_chk.sv
module excp_arbiter_chk #(
  parameter int NUM_EXC = 16,
  localparam int NUM_W = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prof_sec_i,
  input logic [NUM_EXC-1:0] pend_i,
  input logic [NUM_EXC-1:0] en_i,
  input logic               route_q,
  input logic               win_valid_o,
  input logic [NUM_W-1:0]   win_num_o,
  input logic [9:0]         win_prio_o
);

  logic seen_q;
  logic any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_comb begin
    any_req = pend_i[0] | pend_i[1] | pend_i[2] | (pend_i[3] & prof_sec_i);
    for (int i = 4; i < NUM_EXC; i++) any_req = any_req | (pend_i[i] & en_i[i]);
  end

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(pend_i[0]) |-> win_valid_o && win_num_o == '0 &&
      $signed(win_prio_o) == ($past(prof_sec_i) ? -10'sd4 : -10'sd3)); // R3

  AST_SHF_ABOVE_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(prof_sec_i && route_q && pend_i[2] && !pend_i[0]) |->
      win_num_o == NUM_W'(2) && $signed(win_prio_o) == -10'sd3); // R4

  AST_NMI_OVER_HF: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(pend_i[1] && !pend_i[0] && !(prof_sec_i && route_q)) |->
      win_num_o == NUM_W'(1) && $signed(win_prio_o) == -10'sd2); // R2

  AST_LEGACY_ROUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !prof_sec_i |-> !route_q); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !$past(any_req) |-> !win_valid_o && win_num_o == '0 && win_prio_o == '0); // R10

  AST_FIXED_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o && win_num_o < NUM_W'(4) |-> $signed(win_prio_o) < 0); // R8

endmodule

bind excp_arbiter excp_arbiter_chk #(.NUM_EXC(NUM_EXC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prof_sec_i  (prof_sec_i),
  .pend_i      (pend_i),
  .en_i        (en_i),
  .route_q     (route_q),
  .win_valid_o (win_valid_o),
  .win_num_o   (win_num_o),
  .win_prio_o  (win_prio_o)
);

// File: tb/excp_arbiter_bench.sv
`timescale 1ns/1ps
module excp_arbiter_bench;

  localparam int N = 16;
  localparam int NC = N - 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            prof_sec;
  logic [N-1:0]    pend;
  logic [N-1:0]    en;
  logic [NC*8-1:0] prio;
  logic            we;
  logic            wd;
  logic            valid;
  logic [3:0]      num;
  logic [9:0]      wprio;

  int tests = 0;
  int fails = 0;
  bit ctl_m;
  bit done = 0;

  always #2 clk = ~clk;

  excp_arbiter #(.NUM_EXC(N)) u_excp_arbiter (
    .clk(clk), .rst_n(rst_n), .prof_sec_i(prof_sec), .pend_i(pend), .en_i(en),
    .prio_i(prio), .ctl_we_i(we), .ctl_wdata_i(wd),
    .win_valid_o(valid), .win_num_o(num), .win_prio_o(wprio)
  );

  // Reference from requirements R2..R4, R6..R10
  function automatic void model(output bit ev, output int enum_, output int ep);
    int best = 1000;
    ev = 0; enum_ = 0; ep = 0;
    for (int i = 0; i < N; i++) begin
      bit c;
      int p;
      case (i)
        0: begin c = pend[0]; p = prof_sec ? -4 : -3; end
        1: begin c = pend[1]; p = -2; end
        2: begin c = pend[2]; p = (prof_sec && ctl_m) ? -3 : -1; end
        3: begin c = pend[3] && prof_sec; p = -1; end
        default: begin c = pend[i] && en[i]; p = int'(prio[(i-4)*8 +: 8]); end
      endcase
      if (c && p < best) begin
        best = p; ev = 1; enum_ = i; ep = p;
      end
    end
  endfunction

  task automatic check(input bit ev, input int enm, input int ep, input string tag);
    tests++;
    if (valid !== ev || int'(num) !== enm || int'($signed(wprio)) !== ep) begin
      fails++;
      $display("FAIL %s: got v=%0b n=%0d p=%0d exp v=%0b n=%0d p=%0d",
               tag, valid, num, $signed(wprio), ev, enm, ep);
    end
  endtask

  task automatic step(input logic [N-1:0] p, input logic [N-1:0] e,
                      input logic [NC*8-1:0] pr, input bit w, input bit d,
                      input string tag);
    bit ev; int enm; int ep;
    pend = p; en = e; prio = pr; we = w; wd = d;
    model(ev, enm, ep);
    if (w && prof_sec) ctl_m = d;
    @(posedge clk);
    @(negedge clk);
    we = 0;
    check(ev, enm, ep, tag);
  endtask

  task automatic do_reset(input bit prof);
    rst_n = 0; prof_sec = prof; pend = '0; en = '0; prio = '0; we = 0; wd = 0;
    ctl_m = 0;
    repeat (3) @(negedge clk);
    check(0, 0, 0, "R1 reset held");
    rst_n = 1;
    @(negedge clk);
    check(0, 0, 0, "R1 after release");
  endtask

  task automatic rand_run(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      logic [N-1:0] p; logic [NC*8-1:0] pr;
      for (int i = 0; i < N; i++) p[i] = (i < 4) ? ($urandom_range(0, 5) == 0) : $urandom_range(0, 1);
      for (int i = 0; i < NC; i++)
        pr[i*8 +: 8] = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
      step(p, N'($urandom), pr, $urandom_range(0, 7) == 0, 1'($urandom),
           "R7 R8 random");
    end
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NC*8-1:0] pr;
    void'($urandom(32'h1234_5678));
    // Security-extended profile
    do_reset(1);
    step(N'(16'h0004), '0, '0, 0, 0, "R1 route bit starts 0");
    step(N'(16'h0006), '0, '0, 0, 0, "R4 bit0 NMI beats SHF");
    step(N'(16'h0006), '0, '0, 1, 1, "R5 write not yet seen");
    step(N'(16'h0006), '0, '0, 0, 0, "R4 R5 SHF at -3");
    step(N'(16'h0005), '0, '0, 0, 0, "R3 reset -4");
    step(N'(16'h0002), '0, '0, 0, 0, "R3 NMI -2");
    step(N'(16'h000C), '0, '0, 1, 0, "R4 SHF -3 before clear");
    step(N'(16'h000C), '0, '0, 0, 0, "R8 SHF beats NSHF tie");
    step(N'(16'h0008), '0, '0, 0, 0, "R3 NSHF -1");
    step(N'(16'h0002), '0, '0, 0, 0, "R9 NMI with en 0");
    pr = '0; pr[0 +: 8] = 8'd5; pr[8 +: 8] = 8'd3;
    step(N'(16'h0030), N'(16'h0010), pr, 0, 0, "R7 disabled ignored");
    step(N'(16'h0030), N'(16'h0030), pr, 0, 0, "R7 lower value wins");
    pr[0 +: 8] = 8'd3;
    step(N'(16'h0030), N'(16'h0030), pr, 0, 0, "R8 cfg tie lower number");
    pr[0 +: 8] = 8'd255;
    step(N'(16'h0010), N'(16'h0010), pr, 0, 0, "R7 zero extension 255");
    step('0, '1, pr, 0, 0, "R10 idle");
    rand_run(3000);
    // Legacy profile
    do_reset(0);
    step(N'(16'h0007), '0, '0, 0, 0, "R2 reset -3");
    step(N'(16'h0006), '0, '0, 0, 0, "R2 NMI -2");
    step(N'(16'h0004), '0, '0, 0, 0, "R2 HF -1");
    step(N'(16'h0008), '0, '0, 0, 0, "R6 number 3 ignored");
    step(N'(16'h0006), '0, '0, 1, 1, "R6 write ignored a");
    step(N'(16'h0006), '0, '0, 0, 0, "R6 write ignored b");
    rand_run(3000);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule